// File: doc/BRIEF.md
# UART receiver with error-tagged FIFO

This block is the receive half of a serial port. It runs on a clock-enable pulse at sixteen times the bit rate and resynchronises the serial line. It checks each start bit at mid-bit, then shifts in 5 to 8 data bits, least significant bit first. It checks an optional odd or even parity bit and samples the stop bit. Each finished character goes into a 128-entry receive queue. The parity, framing and break outcome for that character is stored in the same entry.

The host reads the head character with a one-cycle holding-register read strobe. The status outputs describe the character at the head of the queue, not the most recent arrival. A line held low for a whole frame stores one zero character tagged as a break. The receiver then ignores the line until it returns high. A character that completes while the queue is full is dropped, and a sticky overrun flag records the loss. A status read clears that flag. When enabled, an interrupt request is raised while any stored character carries an error or while the overrun flag is set.

Top module: `uart_rx_errfifo`

## Requirements
- R1: `data_ready` is 1 exactly when at least one character is stored. A holding-register read with an empty queue changes nothing.
- R2: If a character completes while 128 characters are stored and no read occurs in that cycle, `overrun_err` becomes 1 and the character is dropped. The stored characters and their order are unchanged.
- R3: `overrun_err` stays set until a `stat_rd` pulse clears it.
- R4: `rd_data`, `parity_err`, `framing_err` and `break_err` describe the oldest stored character and advance on each read. All four are 0 while the queue is empty. Data narrower than 8 bits is zero-extended.
- R5: A character whose first stop bit samples 0, and which is not a break, is stored with its framing tag set. A second stop bit is never checked for framing.
- R6: With parity enabled, the parity tag is set when the number of ones in the data bits plus the parity bit is odd under even parity, or even under odd parity. With parity disabled, the parity tag is always 0.
- R7: If every sampled bit of a frame is 0 (start, data, parity if enabled, and all stop bits), exactly one entry is stored: data 0x00, break tag 1, parity and framing tags 0.
- R8: After a break, no further character is assembled until the line has been sampled high. The break entry stays at the head for as long as it is not read, even while the line is still low.
- R9: `lsi_irq` equals `lsi_enable` AND (any stored character has a parity, framing or break tag, OR `overrun_err` is set).
- R10: After reset the queue is empty and `overrun_err`, `lsi_irq` and every status output are 0.
- R11: A start bit needs a high-to-low transition of the line followed by a low sample on the 8th tick. If that sample is high, the start is discarded and nothing is stored.
- R12: `cfg_data_bits` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. `cfg_par_en` enables parity and `cfg_par_even` selects even (1) or odd (0). `cfg_two_stop` adds a second stop bit to the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Clock enable at 16x the bit rate |
| rx_in | input | 1 | Serial receive line, idle high |
| cfg_data_bits | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd |
| cfg_two_stop | input | 1 | Two stop bits per frame |
| lsi_enable | input | 1 | Line-status interrupt enable |
| hold_rd | input | 1 | Pops the head character (one cycle) |
| stat_rd | input | 1 | Status read; clears the overrun flag |
| rd_data | output | 8 | Head character data |
| data_ready | output | 1 | Queue not empty |
| overrun_err | output | 1 | Sticky overrun flag |
| parity_err | output | 1 | Head character parity tag |
| framing_err | output | 1 | Head character framing tag |
| break_err | output | 1 | Head character break tag |
| lsi_irq | output | 1 | Line-status interrupt request |

## Verification
A corrupted queue pointer or tag appears on the read port at the next holding-register read. It shows as a wrong byte, a wrong tag, or `data_ready` disagreeing with the number of characters sent. An error counter that drifts from the queue contents shows up on `lsi_irq`, which the bench compares on every head check. A miscounted bit or tick position shows up one frame later, as a shifted data value or a spurious parity or framing tag. A break detector that does not wait for the line to go high shows up as a second break entry within one frame time of the first.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   typedef struct packed {
      logic       brk;
      logic       fe;
      logic       pe;
      logic [7:0] data;
   } rx_char_t;

   typedef enum logic [2:0] {
      ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_STOP2, ST_BRKW
   } rx_st_e;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad
         $error("rx_line_sync: STAGES must be 0..4");
      end
      if (STAGES == 0) begin : g_pass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2+((STAGES==1)?1:0):0], din};
         end
         assign dout = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/rx_framer.sv
module rx_framer
   import uart_rx_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     tick,
   input  logic     rx,
   input  logic [1:0] cfg_bits,
   input  logic     cfg_par_en,
   input  logic     cfg_par_even,
   input  logic     cfg_two_stop,
   output logic     out_valid,
   output rx_char_t out_char
);
   rx_st_e     st;
   logic [3:0] cnt;
   logic [2:0] bit_idx;
   logic [7:0] shreg;
   logic       par_acc, zero_all, prev_rx;
   logic [2:0] last_idx;

   assign last_idx = {1'b0, cfg_bits} + 3'd4;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; cnt <= '0; bit_idx <= '0; shreg <= '0;
         par_acc <= 1'b0; zero_all <= 1'b1; prev_rx <= 1'b1;
         out_valid <= 1'b0; out_char <= '0;
      end else begin
         out_valid <= 1'b0;
         if (tick) begin
            prev_rx <= rx;
            case (st)
               ST_IDLE: if (prev_rx && !rx) begin
                  st <= ST_START; cnt <= '0;
               end
               ST_START: begin
                  cnt <= cnt + 4'd1;
                  if (cnt == 4'd7) begin
                     cnt <= '0;
                     if (!rx) begin
                        st <= ST_DATA; bit_idx <= '0; shreg <= '0;
                        par_acc <= 1'b0; zero_all <= 1'b1;
                     end else st <= ST_IDLE;
                  end
               end
               ST_DATA: begin
                  cnt <= cnt + 4'd1;
                  if (cnt == 4'd15) begin
                     shreg[bit_idx] <= rx;
                     par_acc <= par_acc ^ rx;
                     zero_all <= zero_all & !rx;
                     if (bit_idx == last_idx) st <= cfg_par_en ? ST_PAR : ST_STOP;
                     else bit_idx <= bit_idx + 3'd1;
                  end
               end
               ST_PAR: begin
                  cnt <= cnt + 4'd1;
                  if (cnt == 4'd15) begin
                     par_acc <= par_acc ^ rx;
                     zero_all <= zero_all & !rx;
                     st <= ST_STOP;
                  end
               end
               ST_STOP: begin
                  cnt <= cnt + 4'd1;
                  if (cnt == 4'd15) begin
                     if (zero_all && !rx && cfg_two_stop) st <= ST_STOP2;
                     else if (zero_all && !rx) begin
                        out_valid <= 1'b1;
                        out_char <= '{brk: 1'b1, fe: 1'b0, pe: 1'b0, data: 8'h00};
                        st <= ST_BRKW;
                     end else begin
                        out_valid <= 1'b1;
                        out_char <= '{brk: 1'b0, fe: !rx,
                                      pe: cfg_par_en & (par_acc ^ !cfg_par_even),
                                      data: shreg};
                        st <= ST_IDLE;
                     end
                  end
               end
               ST_STOP2: begin
                  cnt <= cnt + 4'd1;
                  if (cnt == 4'd15) begin
                     out_valid <= 1'b1;
                     if (!rx) begin
                        out_char <= '{brk: 1'b1, fe: 1'b0, pe: 1'b0, data: 8'h00};
                        st <= ST_BRKW;
                     end else begin
                        out_char <= '{brk: 1'b0, fe: 1'b1,
                                      pe: cfg_par_en & (par_acc ^ !cfg_par_even),
                                      data: shreg};
                        st <= ST_IDLE;
                     end
                  end
               end
               ST_BRKW: if (rx) st <= ST_IDLE;
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   // R7
   brk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_char.brk) |-> (out_char.data == 8'h00 && !out_char.pe && !out_char.fe));
   // R8
   brk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_BRKW) |=> !out_valid);
   // R11
   glitch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_START && tick && cnt == 4'd7 && rx) |=> (st == ST_IDLE));
endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo #(
   parameter int DEPTH = 128,
   parameter int W     = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wr_word,
   input  logic         pop,
   output logic [W-1:0] rd_word,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad
         $error("rx_tag_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wr_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0; rd_ptr <= '0; cnt <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign rd_word = mem[rd_ptr];
   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));

   // R2
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |-> pop);
   // R1
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   // R1
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
endmodule

// File: rtl/uart_rx_errfifo.sv
module uart_rx_errfifo
   import uart_rx_pkg::*;
#(
   parameter int DEPTH       = 128,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick16,
   input  logic       rx_in,
   input  logic [1:0] cfg_data_bits,
   input  logic       cfg_par_en,
   input  logic       cfg_par_even,
   input  logic       cfg_two_stop,
   input  logic       lsi_enable,
   input  logic       hold_rd,
   input  logic       stat_rd,
   output logic [7:0] rd_data,
   output logic       data_ready,
   output logic       overrun_err,
   output logic       parity_err,
   output logic       framing_err,
   output logic       break_err,
   output logic       lsi_irq
);
   localparam int W  = $bits(rx_char_t);
   localparam int CW = $clog2(DEPTH) + 1;

   logic     rx_s, fr_valid, empty, full, push, pop, ovr_q, ovr_set;
   rx_char_t fr_char, head;
   logic [W-1:0]  head_w;
   logic [CW-1:0] err_cnt;
   logic     inc_err, dec_err;

   rx_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .din(rx_in), .dout(rx_s));

   rx_framer i_framer (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .rx(rx_s),
      .cfg_bits(cfg_data_bits), .cfg_par_en(cfg_par_en),
      .cfg_par_even(cfg_par_even), .cfg_two_stop(cfg_two_stop),
      .out_valid(fr_valid), .out_char(fr_char));

   assign pop     = hold_rd && !empty;
   assign push    = fr_valid && (!full || pop);
   assign ovr_set = fr_valid && full && !pop;

   rx_tag_fifo #(.DEPTH(DEPTH), .W(W)) i_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .wr_word(fr_char),
      .pop(pop), .rd_word(head_w), .empty(empty), .full(full));

   assign head    = rx_char_t'(head_w);
   assign inc_err = push && (fr_char.pe || fr_char.fe || fr_char.brk);
   assign dec_err = pop && (head.pe || head.fe || head.brk);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q <= 1'b0; err_cnt <= '0;
      end else begin
         if (ovr_set)      ovr_q <= 1'b1;
         else if (stat_rd) ovr_q <= 1'b0;
         case ({inc_err, dec_err})
            2'b10:   err_cnt <= err_cnt + 1'b1;
            2'b01:   err_cnt <= err_cnt - 1'b1;
            default: err_cnt <= err_cnt;
         endcase
      end
   end

   assign data_ready  = !empty;
   assign rd_data     = empty ? 8'h00 : head.data;
   assign parity_err  = !empty && head.pe;
   assign framing_err = !empty && head.fe;
   assign break_err   = !empty && head.brk;
   assign overrun_err = ovr_q;
   assign lsi_irq     = lsi_enable && (ovr_q || err_cnt != '0);

   // R2
   ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q) |-> $past(fr_valid && full));
   // R3
   ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && !stat_rd) |=> ovr_q);
   // R9
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lsi_irq |-> lsi_enable);
   // R9
   err_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !ovr_q && lsi_enable) |-> !lsi_irq);
endmodule

// File: tb/test_uart_rx_errfifo.sv
module test_uart_rx_errfifo;
   localparam int DEPTH = 128;
   localparam int BITC  = 32;

   logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rx_in = 1'b1;
   logic [1:0] cfg_data_bits = 2'd3;
   logic cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_two_stop = 1'b0;
   logic lsi_enable = 1'b0, hold_rd = 1'b0, stat_rd = 1'b0;
   logic [7:0] rd_data;
   logic data_ready, overrun_err, parity_err, framing_err, break_err, lsi_irq;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit done = 1'b0;
   logic [10:0] q[$];   // {brk, fe, pe, data}
   logic ovr_m = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) tick16 <= rst_n ? ~tick16 : 1'b0;

   uart_rx_errfifo i_uart_rx_errfifo (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in),
      .cfg_data_bits(cfg_data_bits), .cfg_par_en(cfg_par_en),
      .cfg_par_even(cfg_par_even), .cfg_two_stop(cfg_two_stop),
      .lsi_enable(lsi_enable), .hold_rd(hold_rd), .stat_rd(stat_rd),
      .rd_data(rd_data), .data_ready(data_ready), .overrun_err(overrun_err),
      .parity_err(parity_err), .framing_err(framing_err),
      .break_err(break_err), .lsi_irq(lsi_irq));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected<190000", cyc);
         finish_run();
      end
   end

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic model_irq();
      logic any = 1'b0;
      foreach (q[i]) any |= (q[i][10] | q[i][9] | q[i][8]);
      return lsi_enable & (any | ovr_m);
   endfunction

   function automatic int nbits();
      return 5 + int'(cfg_data_bits);
   endfunction

   task automatic model_push(input logic [10:0] e);
      if (q.size() < DEPTH) q.push_back(e);
      else ovr_m = 1'b1;
   endtask

   // sends one frame, updates the model
   task automatic send_frame(input logic [7:0] d_in, input logic par_flip, input logic stop1);
      logic [7:0] d;
      logic pbit, brk;
      d = d_in & 8'((1 << nbits()) - 1);
      pbit = (cfg_par_even ? ^d : ~^d) ^ par_flip;
      rx_in = 1'b0; wclk(BITC);
      for (int i = 0; i < nbits(); i++) begin rx_in = d[i]; wclk(BITC); end
      if (cfg_par_en) begin rx_in = pbit; wclk(BITC); end
      rx_in = stop1; wclk(BITC);
      if (cfg_two_stop) begin rx_in = 1'b1; wclk(BITC); end
      rx_in = 1'b1; wclk(2 * BITC);
      brk = (d == 0) && (!cfg_par_en || !pbit) && !stop1 && !cfg_two_stop;
      if (brk) model_push({3'b100, 8'h00});
      else model_push({1'b0, !stop1, cfg_par_en & par_flip, d});
   endtask

   task automatic check_head(input string tag);
      check({"R1 ready ", tag}, data_ready, q.size() > 0);
      check({"R9 irq ", tag}, lsi_irq, model_irq());
      check({"R3 ovr ", tag}, overrun_err, ovr_m);
      if (q.size() > 0)
         check({"R4 head ", tag}, {break_err, framing_err, parity_err, rd_data}, q[0]);
      else
         check({"R4 empty ", tag}, {break_err, framing_err, parity_err, rd_data}, 11'h0);
   endtask

   task automatic pop_one();
      hold_rd = 1'b1; wclk(1); hold_rd = 1'b0; wclk(1);
      if (q.size() > 0) void'(q.pop_front());
   endtask

   task automatic drain(input string tag);
      while (q.size() > 0) begin check_head(tag); pop_one(); end
      check_head({tag, " drained"});
   endtask

   initial begin
      wclk(3); rst_n = 1'b1; wclk(2);
      // R10 reset state
      check("R10 reset status", {data_ready, overrun_err, parity_err, framing_err,
                                 break_err, lsi_irq, rd_data}, 14'h0);
      // R12 directed 8N1
      send_frame(8'hA5, 1'b0, 1'b1);
      check_head("R12 8N1");
      pop_one();
      // R1 read on empty is harmless
      pop_one();
      check_head("R1 empty read");

      // random rounds: R5 R6 R12
      void'($urandom(32'h5eed1234));
      for (int r = 0; r < 8; r++) begin
         cfg_data_bits = 2'($urandom_range(0, 3));
         cfg_par_en    = 1'($urandom_range(0, 1));
         cfg_par_even  = 1'($urandom_range(0, 1));
         cfg_two_stop  = 1'($urandom_range(0, 1));
         lsi_enable    = 1'($urandom_range(0, 1));
         wclk(BITC);
         for (int k = 0; k < 6; k++)
            send_frame(8'($urandom), $urandom_range(0, 5) == 0, $urandom_range(0, 5) != 0);
         check_head("R9 round");
         drain("R5 R6 R12 round");
      end

      // R11 glitch start
      cfg_data_bits = 2'd3; cfg_par_en = 1'b0; cfg_two_stop = 1'b0; lsi_enable = 1'b1;
      rx_in = 1'b0; wclk(6); rx_in = 1'b1; wclk(4 * BITC);
      check("R11 glitch ignored", data_ready, 1'b0);

      // R7 R8 long break, 8E1
      cfg_par_en = 1'b1; cfg_par_even = 1'b1;
      rx_in = 1'b0; wclk(5 * 11 * BITC);
      check("R8 break held while low", {data_ready, break_err, rd_data}, {2'b11, 8'h00});
      check("R9 irq on break", lsi_irq, 1'b1);
      rx_in = 1'b1; wclk(3 * BITC);
      q.push_back({3'b100, 8'h00});
      check_head("R7 one break entry");
      pop_one();
      check("R7 R8 only one break stored", data_ready, 1'b0);
      // receiver resumes after mark
      send_frame(8'h3C, 1'b0, 1'b1);
      drain("R8 resume");

      // R2 R3 overrun, 8N1
      cfg_par_en = 1'b0; lsi_enable = 1'b0;
      for (int i = 0; i < DEPTH; i++) send_frame(8'(i), 1'b0, 1'b1);
      check("R2 full no ovr", overrun_err, 1'b0);
      send_frame(8'hEE, 1'b0, 1'b1);
      check("R2 ovr set", overrun_err, 1'b1);
      lsi_enable = 1'b1; wclk(1);
      check("R9 irq on ovr", lsi_irq, 1'b1);
      wclk(BITC);
      check("R3 ovr sticky", overrun_err, 1'b1);
      stat_rd = 1'b1; wclk(1); stat_rd = 1'b0; wclk(1); ovr_m = 1'b0;
      check("R3 ovr cleared", overrun_err, 1'b0);
      check("R2 count kept", q.size(), DEPTH);
      drain("R2 intact");
      finish_run();
   end
endmodule